// File: doc/BRIEF.md
# Three-Phase Inverter Gate Generator with Dead Time

This block turns three per-phase duty commands into the six gate signals of a three-leg inverter. Each leg has a high-side and a low-side switch. A shared up/down counter defines a center-aligned PWM period. Each leg compares the counter against its duty value to form a nominal high-side state, and the low side takes the complement. A programmable dead time holds back the switch that is about to turn on, so that the two switches of a leg never conduct together. A sampling trigger for an external converter fires a programmable number of clocks after the counter reaches its turning point.

The period, the three duties, the dead time and the trigger delay pass through shadow registers. These registers reload only when the counter returns to zero, so a new command never splits a PWM period. A static mode pin adapts the high-side drive level to the leg construction: either every switch is N-channel, or the high side is P-channel and is driven active-low. A fault input and the enable input both force all six switches to their off level on the next clock edge.

Top module: `pwm3_gate_top`

## Requirements
- R1: With a programmed period P > 0, the counter rises from 0 to P and falls back to 0, so one PWM period lasts 2·P clocks. A phase is nominally high while the count is below its duty value, which gives 2·duty−1 nominally-high clocks per period for 0 < duty < P.
- R2: In every leg, the high-side and low-side switches are never on in the same clock.
- R3: After each change of a leg's nominal state, the switch that turns on waits the programmed dead time D clocks. A contiguous nominal window of L clocks therefore yields max(0, L−D) on-clocks for that switch.
- R4: A duty of 0 keeps the high side off and the low side on for the whole period. A duty at or above P keeps the high side on and the low side off for the whole period. In both cases the dead time inserts no gaps.
- R5: New period, duty, dead-time and delay inputs take effect only from the clock in which the counter is back at zero. Until then, the values captured at the previous zero stay in force.
- R6: `adc_trig` is a one-clock pulse, once per PWM period. The first pulse after enabling appears on rising edge number P+DLY+1, counting the first edge that samples `enable` high as edge 1. DLY is the trigger delay and must be below 2·P.
- R7: With a period of 0, the counter stays at zero, no trigger is issued, and each leg holds a constant state set by R4.
- R8: `hs_pchan` = 0 drives every gate active-high. `hs_pchan` = 1 drives the three high-side gates active-low, so their off level is 1. Low-side gates are active-high in both modes.
- R9: While `fault` is 1 or `enable` is 0, all six gates are at their off level from the next rising edge. This also holds during reset, in either mode.
- R10: While `enable` is 0, the counter is held at zero, no trigger pulse is produced, and the shadow registers copy their inputs on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the counter and allow gates to switch |
| fault | input | 1 | Forces all switches off while 1 |
| hs_pchan | input | 1 | 0: all-N legs; 1: P-channel high side, driven active-low |
| period | input | 16 | Counter turning value P |
| duty_a | input | 16 | Duty command for leg 0 |
| duty_b | input | 16 | Duty command for leg 1 |
| duty_c | input | 16 | Duty command for leg 2 |
| dead_cyc | input | 8 | Dead time in clocks |
| trig_delay | input | 16 | Clocks from counter peak to trigger |
| gate_hi | output | 3 | High-side gate drives, bit n = leg n |
| gate_lo | output | 3 | Low-side gate drives, bit n = leg n |
| adc_trig | output | 1 | One-clock converter sampling pulse |

## Verification
Gate outputs are registered one clock behind the counter, and the trigger is registered one clock behind its delay expiry. The bench therefore counts rising edges from the edge that first samples `enable` and expects the first trigger at edge P+DLY+1. Duty-cycle and dead-time results are measured as on-clock totals over a full window of 2·P clocks, taken only after one complete period has settled, so the window's alignment does not matter. The fault and disable responses are sampled one edge after the input changes. The shadow-register test switches a duty command one clock past a zero and counts the outputs up to and beyond the next zero. All sampling happens one clock phase away from the active edge.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    parameter int unsigned CNT_W = 16;
    parameter int unsigned DT_W  = 8;
    parameter int unsigned N_PH  = 3;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DT_W-1:0]  dt_t;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    // Values that reload together when the counter is at zero
    typedef struct packed {
        cnt_t period;
        cnt_t trig_dly;
        dt_t  dead;
    } tb_cfg_t;

    // Nominal high-side state of one leg
    function automatic logic nominal_high(cnt_t cnt, cnt_t duty, cnt_t period);
        if (duty == '0) begin
            return 1'b0;
        end
        if (duty >= period) begin
            return 1'b1;
        end
        return (cnt < duty);
    endfunction

    function automatic dt_t sat_inc(dt_t v);
        return (v == {DT_W{1'b1}}) ? v : v + dt_t'(1);
    endfunction

endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  cnt_t              period_in,
    input  cnt_t              dly_in,
    input  dt_t               dead_in,
    input  cnt_t [N_PH-1:0]   duty_in,
    output cnt_t              cnt_o,
    output tb_cfg_t           cfg_o,
    output cnt_t [N_PH-1:0]   duty_o,
    output logic              peak_o
);

    cnt_t            cnt_q, cnt_n;
    slope_e          slope_q, slope_n;
    tb_cfg_t         cfg_q;
    cnt_t [N_PH-1:0] duty_q;

    always_comb begin
        cnt_n   = cnt_q;
        slope_n = slope_q;
        if (!enable || cfg_q.period == '0) begin
            cnt_n = '0;
        end else if (slope_q == SLOPE_UP) begin
            if (cnt_q >= cfg_q.period) begin
                cnt_n   = cnt_q - cnt_t'(1);
                slope_n = SLOPE_DOWN;
            end else begin
                cnt_n = cnt_q + cnt_t'(1);
            end
        end else begin
            cnt_n = cnt_q - cnt_t'(1);
        end
        if (cnt_n == '0) begin
            slope_n = SLOPE_UP;
        end
    end

    assign peak_o = enable && (slope_q == SLOPE_UP) && (cfg_q.period != '0)
                    && (cnt_q >= cfg_q.period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            slope_q <= SLOPE_UP;
            cfg_q   <= '0;
            duty_q  <= '0;
        end else begin
            cnt_q   <= cnt_n;
            slope_q <= slope_n;
            if (cnt_n == '0) begin
                cfg_q  <= '{period: period_in, trig_dly: dly_in, dead: dead_in};
                duty_q <= duty_in;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign cfg_o  = cfg_q;
    assign duty_o = duty_q;

endmodule

// File: rtl/pwm3_adc_sync.sv
module pwm3_adc_sync
    import pwm3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic peak_i,
    input  cnt_t dly_i,
    output logic trig_o
);

    cnt_t left_q;
    logic armed_q;
    logic fire;

    // A new peak restarts the delay and drops any pending countdown
    always_comb begin
        if (peak_i) begin
            fire = (dly_i == '0);
        end else begin
            fire = enable && armed_q && (left_q == cnt_t'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed_q <= 1'b0;
            left_q  <= '0;
            trig_o  <= 1'b0;
        end else begin
            trig_o <= fire;
            if (peak_i) begin
                armed_q <= (dly_i != '0);
                left_q  <= dly_i;
            end else if (armed_q) begin
                left_q <= left_q - cnt_t'(1);
                if (left_q == cnt_t'(1)) begin
                    armed_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
    import pwm3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t cnt_i,
    input  cnt_t duty_i,
    input  cnt_t period_i,
    input  dt_t  dead_i,
    input  logic allow_i,
    output logic hi_o,
    output logic lo_o
);

    logic nom, nom_q, settled;
    dt_t  run_q, run_now;

    assign nom     = nominal_high(cnt_i, duty_i, period_i);
    // Clocks the nominal state has held, zero in the clock it changes
    assign run_now = (nom == nom_q) ? sat_inc(run_q) : '0;
    assign settled = (run_now >= dead_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            nom_q <= 1'b0;
            run_q <= '0;
            hi_o  <= 1'b0;
            lo_o  <= 1'b0;
        end else begin
            nom_q <= nom;
            run_q <= run_now;
            hi_o  <= allow_i && nom && settled;
            lo_o  <= allow_i && !nom && settled;
        end
    end

endmodule

// File: rtl/pwm3_gate_top.sv
module pwm3_gate_top
    import pwm3_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 fault,
    input  logic                 hs_pchan,
    input  logic [CNT_W-1:0]     period,
    input  logic [CNT_W-1:0]     duty_a,
    input  logic [CNT_W-1:0]     duty_b,
    input  logic [CNT_W-1:0]     duty_c,
    input  logic [DT_W-1:0]      dead_cyc,
    input  logic [CNT_W-1:0]     trig_delay,
    output logic [N_PH-1:0]      gate_hi,
    output logic [N_PH-1:0]      gate_lo,
    output logic                 adc_trig
);

    cnt_t            cnt;
    tb_cfg_t         cfg;
    cnt_t [N_PH-1:0] duty_cmd;
    cnt_t [N_PH-1:0] duty_sh;
    logic            peak;
    logic            allow;
    logic [N_PH-1:0] hi_raw;
    logic [N_PH-1:0] lo_raw;

    assign duty_cmd = {duty_c, duty_b, duty_a};
    assign allow    = enable && !fault;

    pwm3_timebase tb_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .period_in (period),
        .dly_in    (trig_delay),
        .dead_in   (dead_cyc),
        .duty_in   (duty_cmd),
        .cnt_o     (cnt),
        .cfg_o     (cfg),
        .duty_o    (duty_sh),
        .peak_o    (peak)
    );

    pwm3_adc_sync trig_i (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .peak_i (peak),
        .dly_i  (cfg.trig_dly),
        .trig_o (adc_trig)
    );

    for (genvar g = 0; g < N_PH; g++) begin : g_leg
        pwm3_leg leg_i (
            .clk      (clk),
            .rst      (rst),
            .cnt_i    (cnt),
            .duty_i   (duty_sh[g]),
            .period_i (cfg.period),
            .dead_i   (cfg.dead),
            .allow_i  (allow),
            .hi_o     (hi_raw[g]),
            .lo_o     (lo_raw[g])
        );
    end

    // P-channel high side conducts on a low gate level
    assign gate_hi = hi_raw ^ {N_PH{hs_pchan}};
    assign gate_lo = lo_raw;

endmodule

// File: rtl/pwm3_gate_chk.sv
module pwm3_gate_chk
    import pwm3_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic            fault,
    input logic            hs_pchan,
    input logic [N_PH-1:0] gate_hi,
    input logic [N_PH-1:0] gate_lo,
    input logic            adc_trig
);

    for (genvar g = 0; g < N_PH; g++) begin : g_leg
        // R2
        no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
            !((gate_hi[g] ^ hs_pchan) && gate_lo[g]));
    end

    // R9
    fault_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> ((gate_lo == '0) && ((gate_hi ^ {N_PH{hs_pchan}}) == '0)));

    // R9
    disable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ((gate_lo == '0) && ((gate_hi ^ {N_PH{hs_pchan}}) == '0)));

    // R10
    trig_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !adc_trig);

endmodule

bind pwm3_gate_top pwm3_gate_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .fault    (fault),
    .hs_pchan (hs_pchan),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .adc_trig (adc_trig)
);

// File: tb/pwm3_gate_top_tb_top.sv
module pwm3_gate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        fault;
    logic        hs_pchan;
    logic [15:0] period;
    logic [15:0] duty_a, duty_b, duty_c;
    logic [7:0]  dead_cyc;
    logic [15:0] trig_delay;
    logic [2:0]  gate_hi, gate_lo;
    logic        adc_trig;

    always #5 clk = ~clk;

    pwm3_gate_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .fault      (fault),
        .hs_pchan   (hs_pchan),
        .period     (period),
        .duty_a     (duty_a),
        .duty_b     (duty_b),
        .duty_c     (duty_c),
        .dead_cyc   (dead_cyc),
        .trig_delay (trig_delay),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo),
        .adc_trig   (adc_trig)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] da;
        logic [15:0] db;
        logic [15:0] dc;
        logic [7:0]  dt;
        logic [15:0] dly;
        logic        pm;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{16'd10, 16'd3, 16'd5,  16'd8,  8'd2, 16'd4,  1'b0},
        '{16'd10, 16'd0, 16'd10, 16'd12, 8'd3, 16'd0,  1'b0},
        '{16'd16, 16'd4, 16'd1,  16'd16, 8'd0, 16'd7,  1'b1},
        '{16'd8,  16'd2, 16'd6,  16'd7,  8'd4, 16'd15, 1'b1},
        '{16'd1,  16'd1, 16'd0,  16'd1,  8'd0, 16'd1,  1'b0}
    };

    int n_run  = 0;
    int n_fail = 0;
    int overlap = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Nominal-high clocks per period from R1 and R4
    function automatic int hi_window(input int p, input int d);
        if (d == 0) return 0;
        if (d >= p) return 2 * p;
        return 2 * d - 1;
    endfunction

    // On-clocks of one switch from R3 and R4
    function automatic int on_clocks(input int win, input int full, input int dt);
        if (win == full) return full;
        if (win == 0) return 0;
        return (win > dt) ? win - dt : 0;
    endfunction

    function automatic int duty_of(input vec_t v, input int ph);
        if (ph == 0) return int'(v.da);
        if (ph == 1) return int'(v.db);
        return int'(v.dc);
    endfunction

    // R2 monitor, sampled away from both edges
    always begin
        @(negedge clk);
        #1;
        if (rst === 1'b0) begin
            for (int g = 0; g < 3; g++) begin
                if ((gate_hi[g] ^ hs_pchan) && gate_lo[g]) overlap++;
            end
        end
    end

    task automatic load_cfg(input vec_t v);
        @(negedge clk);
        enable     = 1'b0;
        period     = v.per;
        duty_a     = v.da;
        duty_b     = v.db;
        duty_c     = v.dc;
        dead_cyc   = v.dt;
        trig_delay = v.dly;
        hs_pchan   = v.pm;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int hi_cnt [3];
        int lo_cnt [3];
        int trig_cnt;
        int bad;
        vec_t v;

        rst = 1'b1; enable = 1'b0; fault = 1'b0; hs_pchan = 1'b1;
        period = '0; duty_a = '0; duty_b = '0; duty_c = '0;
        dead_cyc = '0; trig_delay = '0;

        // Reset state, R8 and R9: P-channel high side rests at 1
        repeat (3) @(negedge clk);
        check("R8 R9", "reset gate_hi", int'(gate_hi), 7);
        check("R9", "reset gate_lo", int'(gate_lo), 0);
        check("R10", "reset adc_trig", int'(adc_trig), 0);
        rst = 1'b0;

        // Vector table: timing of the first trigger and per-period on-clocks
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            load_cfg(v);
            enable = 1'b1;
            k = 0;
            while (k < 200 && !adc_trig) begin
                @(negedge clk);
                k++;
            end
            check("R6", $sformatf("vec %0d first trigger edge", i), k,
                  int'(v.per) + int'(v.dly) + 1);
            repeat (2 * int'(v.per)) @(negedge clk);
            for (int g = 0; g < 3; g++) begin
                hi_cnt[g] = 0;
                lo_cnt[g] = 0;
            end
            trig_cnt = 0;
            for (int c = 0; c < 2 * int'(v.per); c++) begin
                @(negedge clk);
                for (int g = 0; g < 3; g++) begin
                    if (gate_hi[g] ^ v.pm) hi_cnt[g]++;
                    if (gate_lo[g]) lo_cnt[g]++;
                end
                if (adc_trig) trig_cnt++;
            end
            for (int g = 0; g < 3; g++) begin
                k = hi_window(int'(v.per), duty_of(v, g));
                check("R1 R3 R4 R8", $sformatf("vec %0d leg %0d high on-clocks", i, g),
                      hi_cnt[g], on_clocks(k, 2 * int'(v.per), int'(v.dt)));
                check("R1 R3 R4", $sformatf("vec %0d leg %0d low on-clocks", i, g),
                      lo_cnt[g], on_clocks(2 * int'(v.per) - k, 2 * int'(v.per), int'(v.dt)));
            end
            check("R6", $sformatf("vec %0d triggers per period", i), trig_cnt, 1);
        end

        // R5: duty change one clock after a zero waits for the next zero
        v = '{16'd10, 16'd3, 16'd0, 16'd0, 8'd0, 16'd0, 1'b0};
        load_cfg(v);
        enable = 1'b1;
        repeat (21) @(negedge clk);
        duty_a = 16'd7;
        hi_cnt[0] = 0;
        for (int c = 0; c < 19; c++) begin
            @(negedge clk);
            if (gate_hi[0]) hi_cnt[0]++;
        end
        check("R5", "old duty held until zero", hi_cnt[0], 4);
        hi_cnt[0] = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (gate_hi[0]) hi_cnt[0]++;
        end
        check("R5", "new duty after zero", hi_cnt[0], 13);

        // R7: period zero
        v = '{16'd0, 16'd0, 16'd5, 16'd0, 8'd2, 16'd0, 1'b0};
        load_cfg(v);
        enable = 1'b1;
        @(negedge clk);
        trig_cnt = 0; hi_cnt[0] = 0; hi_cnt[1] = 0; lo_cnt[0] = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (adc_trig) trig_cnt++;
            if (gate_hi[0]) hi_cnt[0]++;
            if (gate_hi[1]) hi_cnt[1]++;
            if (gate_lo[0]) lo_cnt[0]++;
        end
        check("R7", "triggers with period zero", trig_cnt, 0);
        check("R7 R4", "duty 0 high on-clocks", hi_cnt[0], 0);
        check("R7 R4", "duty 0 low on-clocks", lo_cnt[0], 40);
        check("R7 R4", "duty 5 high on-clocks", hi_cnt[1], 40);

        // R9: fault forces off in P-channel mode
        v = '{16'd10, 16'd5, 16'd5, 16'd5, 8'd1, 16'd2, 1'b1};
        load_cfg(v);
        enable = 1'b1;
        repeat (30) @(negedge clk);
        fault = 1'b1;
        @(negedge clk);
        check("R9 R8", "fault gate_hi", int'(gate_hi), 7);
        check("R9", "fault gate_lo", int'(gate_lo), 0);
        bad = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (gate_hi != 3'b111 || gate_lo != 3'b000) bad++;
        end
        check("R9", "fault held off clocks", bad, 0);
        fault = 1'b0;
        repeat (25) @(negedge clk);

        // R9 and R10: disable in all-N mode
        hs_pchan = 1'b0;
        repeat (25) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R9", "disable gate_hi", int'(gate_hi), 0);
        check("R9", "disable gate_lo", int'(gate_lo), 0);
        bad = 0;
        trig_cnt = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (gate_hi != 3'b000 || gate_lo != 3'b000) bad++;
            if (adc_trig) trig_cnt++;
        end
        check("R10", "triggers while disabled", trig_cnt, 0);
        check("R10", "on-clocks while disabled", bad, 0);

        check("R2", "shoot-through clocks", overlap, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule